// File: doc/BRIEF.md
# Multi-rate TDM stream port

This block is a single serial stream port for a shared backplane telephony bus. One data line carries 8-bit time slots at 8, 4 or 2 Mbit/s. The line is locked to an active-low frame pulse. A system clock runs at four ticks per 8 MHz bus bit, and the block keeps one frame as 4096 ticks, whichever rate is selected. Transmit bytes are taken from a slot-indexed register array and shifted out most significant bit first. A per-slot enable bit decides whether the line is driven in each slot. Received bits are assembled into bytes and stored in a second slot-indexed array, and each completed byte is also announced with a one-tick strobe.

The receive sampling point can be moved to half, three quarters or the full bit period. The transmit driver can let go of the line one tick before the end of a slot, or exactly on the slot boundary. These two settings let the port work with peers that are loose on bus timing. A configuration wrapper drives the rate, sampling and release inputs and holds them static while a frame is running.

A small state machine handles alignment. It has three states. ST_HUNT waits for the first frame pulse. ST_LOCKED runs with good alignment. ST_FAULT keeps running after an alignment error was seen. The transitions are:
- HUNT to LOCKED on the first frame pulse.
- LOCKED to FAULT on a misplaced pulse or a missing pulse.
- FAULT stays in FAULT until reset.

Top module: `tdm_stream_port`

## Requirements
- R1: After reset, the port is in ST_HUNT. tx_oe, tx_d, rx_valid and sync_err are 0, and rx_slot and rx_byte read 0.
- R2: A frame pulse is frame_n low for one tick. The tick after it is tick 0 of the frame, which is the first tick of slot 0, bit b7. After that the tick counter advances by one per clock. A pulse seen on the last tick (4095) of a frame keeps the frame period at 4096 ticks.
- R3: rate_sel selects the rate: 0 is 8 Mbit/s (4 ticks per bit, 128 slots), 1 is 4 Mbit/s (8 ticks, 64 slots), and 2 or 3 is 2 Mbit/s (16 ticks, 32 slots). Slot s occupies ticks 8·L·s to 8·L·s+8·L−1, where L is the bit length in ticks.
- R4: In a driven slot, tx_d carries bit b7 of the slot's transmit byte during the first bit period and bit b0 during the eighth. Each bit is held for its whole period.
- R5: The transmit array is written with tx_wr: tx_waddr selects the slot, tx_wdata is the byte and tx_wslot_en is the slot's enable bit. All enable bits reset to 0. In a slot whose enable bit is 0, tx_oe is 0 for the whole slot. Whenever tx_oe is 0, tx_d is 0.
- R6: With early_rel = 1, tx_oe is 0 on the last tick of bit b0 of every slot. With early_rel = 0, tx_oe stays 1 through that tick and falls on the boundary only if the next slot is disabled.
- R7: samp_sel selects the tick within each bit on which rx_d is captured: 1 is phase L/2−1 (half period), 2 is phase L−1 (full period), and 0 or 3 is phase 3L/4−1 (three quarters).
- R8: When bit b0 of slot s is captured, the byte (first received bit in the MSB) is written into the receive array at index s. In the next tick rx_valid is 1 for exactly one tick, with rx_slot = s and rx_byte set to the byte. rx_rdata returns the array entry at rx_raddr combinationally.
- R9: Once running, a frame pulse on any tick other than 4095, or a missing pulse on tick 4095, moves the port to ST_FAULT. sync_err is 1 from the next tick and stays 1. A misplaced pulse still realigns the counter, and a missing pulse lets the counter wrap to 0.
- R10: In ST_HUNT the line is never driven, nothing is received, and rx_valid stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 4 ticks per 8 MHz bus bit |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_sel | input | 2 | Stream rate select |
| samp_sel | input | 2 | Receive sampling point select |
| early_rel | input | 1 | 1: release the line one tick before the slot end |
| frame_n | input | 1 | Active-low frame pulse |
| rx_d | input | 1 | Serial receive data |
| tx_d | output | 1 | Serial transmit data |
| tx_oe | output | 1 | Transmit driver enable (0 = high impedance) |
| tx_wr | input | 1 | Transmit array write strobe |
| tx_waddr | input | 7 | Transmit array write slot |
| tx_wdata | input | 8 | Transmit byte |
| tx_wslot_en | input | 1 | Enable bit for the written slot |
| rx_raddr | input | 7 | Receive array read slot |
| rx_rdata | output | 8 | Receive array read data |
| rx_valid | output | 1 | One-tick strobe for a completed byte |
| rx_slot | output | 7 | Slot index of the completed byte |
| rx_byte | output | 8 | Completed byte |
| sync_err | output | 1 | Sticky alignment error |

## Verification
With full-period sampling, the capture of bit b0 of the last slot falls on tick 4095. That is also the tick on which a correct frame pulse arrives, so byte completion and frame realignment happen in the same cycle. The bench provokes this at 2 Mbit/s by running a whole frame and pulsing frame_n on tick 4095. It then checks, in the next tick, that rx_valid reports slot 31 with the right byte. In that same tick tx_d must already show slot 0, bit b7, and sync_err must stay clear. Each sampling mode is told apart by driving a different byte in each quarter of every bit.

// File: rtl/tdm_port_pkg.sv
package tdm_port_pkg;

    typedef enum logic [1:0] {
        RATE_8M = 2'd0,
        RATE_4M = 2'd1,
        RATE_2M = 2'd2
    } rate_e;

    typedef enum logic [1:0] {
        SMP_3Q   = 2'd0,
        SMP_HALF = 2'd1,
        SMP_FULL = 2'd2
    } samp_e;

    typedef enum logic [1:0] {
        ST_HUNT   = 2'd0,
        ST_LOCKED = 2'd1,
        ST_FAULT  = 2'd2
    } sync_state_e;

endpackage

// File: rtl/tdm_frame_timer.sv
module tdm_frame_timer
    import tdm_port_pkg::*;
#(
    parameter int FRAME_TICKS = 4096,
    parameter int TW          = 12
)(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_n,
    output logic [TW-1:0] tick,
    output logic          running,
    output logic          sync_err
);

    localparam logic [TW-1:0] LAST_TICK = TW'(FRAME_TICKS - 1);

    sync_state_e   state_q, state_nx;
    logic [TW-1:0] tick_q;
    logic          wrap, misplaced, missing;

    // Frame-boundary events relative to the running counter
    always_comb begin
        wrap      = (tick_q == LAST_TICK);
        misplaced = !frame_n && !wrap;
        missing   = frame_n && wrap;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
        end else begin
            state_q <= state_nx;
        end
    end

    // Next-state logic
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_HUNT:   if (!frame_n) state_nx = ST_LOCKED;
            ST_LOCKED: if (misplaced || missing) state_nx = ST_FAULT;
            ST_FAULT:  state_nx = ST_FAULT;
            default:   state_nx = ST_HUNT;
        endcase
    end

    // Tick counter: a pulse or the frame end restarts it
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_q <= '0;
        end else if (!frame_n || wrap) begin
            tick_q <= '0;
        end else if (state_q != ST_HUNT) begin
            tick_q <= tick_q + TW'(1);
        end
    end

    // Outputs
    always_comb begin
        running  = (state_q != ST_HUNT);
        sync_err = (state_q == ST_FAULT);
        tick     = tick_q;
    end

endmodule

// File: rtl/tdm_slot_decode.sv
module tdm_slot_decode
    import tdm_port_pkg::*;
#(
    parameter int TW      = 12,
    parameter int SW      = 7,
    parameter int KW      = 3,
    parameter int BASE_SH = 2
)(
    input  logic [TW-1:0] tick,
    input  logic [1:0]    rate_sel,
    input  logic [1:0]    samp_sel,
    output logic [SW-1:0] slot,
    output logic [KW-1:0] bit_k,
    output logic          bit_end,
    output logic          sample_now
);

    logic [2:0]    shamt;
    logic [TW-1:0] len_m1, phase, samp_pt, bit_glb;

    // Bit length from the selected rate
    always_comb begin
        unique case (rate_e'(rate_sel))
            RATE_8M: shamt = 3'(BASE_SH);
            RATE_4M: shamt = 3'(BASE_SH + 1);
            default: shamt = 3'(BASE_SH + 2);
        endcase
        len_m1 = (TW'(1) << shamt) - TW'(1);
    end

    // Sampling phase within the bit
    always_comb begin
        unique case (samp_e'(samp_sel))
            SMP_HALF: samp_pt = len_m1 >> 1;
            SMP_FULL: samp_pt = len_m1;
            default:  samp_pt = len_m1 - ((len_m1 + TW'(1)) >> 2);
        endcase
    end

    // Position of the current tick in the frame
    always_comb begin
        phase      = tick & len_m1;
        bit_glb    = tick >> shamt;
        bit_k      = bit_glb[KW-1:0];
        slot       = SW'(bit_glb >> KW);
        bit_end    = (phase == len_m1);
        sample_now = (phase == samp_pt);
    end

endmodule

// File: rtl/tdm_tx_lane.sv
module tdm_tx_lane #(
    parameter int SLOTS = 128,
    parameter int SW    = 7,
    parameter int W     = 8,
    parameter int KW    = 3
)(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [SW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic          wen_bit,
    input  logic          running,
    input  logic [SW-1:0] slot,
    input  logic [KW-1:0] bit_k,
    input  logic          bit_end,
    input  logic          early,
    output logic          tx_d,
    output logic          tx_oe
);

    localparam logic [KW-1:0] LAST_K = KW'(W - 1);

    logic [W-1:0]     data_q [SLOTS];
    logic [SLOTS-1:0] en_q;
    logic [SLOTS-1:0] hit;

    // Per-slot write decode
    for (genvar i = 0; i < SLOTS; i++) begin : g_hit
        assign hit[i] = wr && (waddr == SW'(i));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '0;
        end else begin
            for (int i = 0; i < SLOTS; i++) begin
                if (hit[i]) en_q[i] <= wen_bit;
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < SLOTS; i++) begin
            if (hit[i]) data_q[i] <= wdata;
        end
    end

    logic [W-1:0] cur;
    logic         early_gap, drive;

    always_comb begin
        cur       = data_q[slot];
        early_gap = early && bit_end && (bit_k == LAST_K);
        drive     = running && en_q[slot] && !early_gap;
        tx_oe     = drive;
        tx_d      = drive && cur[LAST_K - bit_k];
    end

endmodule

// File: rtl/tdm_rx_lane.sv
module tdm_rx_lane #(
    parameter int SLOTS = 128,
    parameter int SW    = 7,
    parameter int W     = 8,
    parameter int KW    = 3
)(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          running,
    input  logic          sample_now,
    input  logic [SW-1:0] slot,
    input  logic [KW-1:0] bit_k,
    input  logic          rx_d,
    input  logic [SW-1:0] raddr,
    output logic [W-1:0]  rdata,
    output logic          valid,
    output logic [SW-1:0] vslot,
    output logic [W-1:0]  vbyte
);

    logic [W-2:0] sh_q;
    logic [W-1:0] mem_q [SLOTS];
    logic         take, byte_done;
    logic [W-1:0] full_byte;

    always_comb begin
        take      = running && sample_now;
        byte_done = take && (bit_k == KW'(W - 1));
        full_byte = {sh_q, rx_d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q  <= '0;
            valid <= 1'b0;
            vslot <= '0;
            vbyte <= '0;
        end else begin
            valid <= byte_done;
            if (take) sh_q <= full_byte[W-2:0];
            if (byte_done) begin
                vslot <= slot;
                vbyte <= full_byte;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (byte_done) mem_q[slot] <= full_byte;
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/tdm_stream_port.sv
module tdm_stream_port
    import tdm_port_pkg::*;
#(
    parameter int SLOTS         = 128,
    parameter int SLOT_BITS     = 8,
    parameter int TICKS_PER_BIT = 4
)(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [1:0]               rate_sel,
    input  logic [1:0]               samp_sel,
    input  logic                     early_rel,
    input  logic                     frame_n,
    input  logic                     rx_d,
    output logic                     tx_d,
    output logic                     tx_oe,
    input  logic                     tx_wr,
    input  logic [$clog2(SLOTS)-1:0] tx_waddr,
    input  logic [SLOT_BITS-1:0]     tx_wdata,
    input  logic                     tx_wslot_en,
    input  logic [$clog2(SLOTS)-1:0] rx_raddr,
    output logic [SLOT_BITS-1:0]     rx_rdata,
    output logic                     rx_valid,
    output logic [$clog2(SLOTS)-1:0] rx_slot,
    output logic [SLOT_BITS-1:0]     rx_byte,
    output logic                     sync_err
);

    localparam int SW          = $clog2(SLOTS);
    localparam int KW          = $clog2(SLOT_BITS);
    localparam int BASE_SH     = $clog2(TICKS_PER_BIT);
    localparam int FRAME_TICKS = SLOTS * SLOT_BITS * TICKS_PER_BIT;
    localparam int TW          = $clog2(FRAME_TICKS);

    logic [TW-1:0] tick;
    logic          running;
    logic [SW-1:0] slot;
    logic [KW-1:0] bit_k;
    logic          bit_end, sample_now;

    tdm_frame_timer #(.FRAME_TICKS(FRAME_TICKS), .TW(TW)) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .frame_n  (frame_n),
        .tick     (tick),
        .running  (running),
        .sync_err (sync_err)
    );

    tdm_slot_decode #(.TW(TW), .SW(SW), .KW(KW), .BASE_SH(BASE_SH)) dec_i (
        .tick       (tick),
        .rate_sel   (rate_sel),
        .samp_sel   (samp_sel),
        .slot       (slot),
        .bit_k      (bit_k),
        .bit_end    (bit_end),
        .sample_now (sample_now)
    );

    tdm_tx_lane #(.SLOTS(SLOTS), .SW(SW), .W(SLOT_BITS), .KW(KW)) tx_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (tx_wr),
        .waddr   (tx_waddr),
        .wdata   (tx_wdata),
        .wen_bit (tx_wslot_en),
        .running (running),
        .slot    (slot),
        .bit_k   (bit_k),
        .bit_end (bit_end),
        .early   (early_rel),
        .tx_d    (tx_d),
        .tx_oe   (tx_oe)
    );

    tdm_rx_lane #(.SLOTS(SLOTS), .SW(SW), .W(SLOT_BITS), .KW(KW)) rx_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .running    (running),
        .sample_now (sample_now),
        .slot       (slot),
        .bit_k      (bit_k),
        .rx_d       (rx_d),
        .raddr      (rx_raddr),
        .rdata      (rx_rdata),
        .valid      (rx_valid),
        .vslot      (rx_slot),
        .vbyte      (rx_byte)
    );

endmodule

// File: rtl/tdm_stream_port_chk.sv
module tdm_stream_port_chk #(
    parameter int TW          = 12,
    parameter int KW          = 3,
    parameter int W           = 8,
    parameter int FRAME_TICKS = 4096
)(
    input logic          clk,
    input logic          rst_n,
    input logic          frame_n,
    input logic          early_rel,
    input logic          running,
    input logic          sync_err,
    input logic [TW-1:0] tick,
    input logic [KW-1:0] bit_k,
    input logic          bit_end,
    input logic          tx_oe,
    input logic          tx_d,
    input logic          rx_valid
);

    assert_valid_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    assert_quiet_hunt_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> (!tx_oe && !rx_valid && !sync_err));

    assert_realign_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !frame_n) |=> (tick == '0));

    assert_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (running && frame_n && tick != TW'(FRAME_TICKS - 1)) |=> (tick == TW'($past(tick) + 1)));

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sync_err |=> sync_err);

    assert_early_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (early_rel && bit_end && bit_k == KW'(W - 1)) |-> !tx_oe);

    assert_quiet_line_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_oe |-> !tx_d);

endmodule

bind tdm_stream_port tdm_stream_port_chk #(
    .TW(TW), .KW(KW), .W(SLOT_BITS), .FRAME_TICKS(FRAME_TICKS)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_n   (frame_n),
    .early_rel (early_rel),
    .running   (running),
    .sync_err  (sync_err),
    .tick      (tick),
    .bit_k     (bit_k),
    .bit_end   (bit_end),
    .tx_oe     (tx_oe),
    .tx_d      (tx_d),
    .rx_valid  (rx_valid)
);

// File: tb/tdm_stream_port_tb_top.sv
module tdm_stream_port_tb_top;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst_n = 1'b0;
    logic [1:0] rate_sel = 2'd0, samp_sel = 2'd0;
    logic       early_rel = 1'b0, frame_n = 1'b1, rx_d = 1'b0;
    logic       tx_d, tx_oe, tx_wr = 1'b0, tx_wslot_en = 1'b0;
    logic [6:0] tx_waddr = '0, rx_raddr = '0, rx_slot;
    logic [7:0] tx_wdata = '0, rx_rdata, rx_byte;
    logic       rx_valid, sync_err;

    tdm_stream_port dut_i (.*);

    int checks = 0, errors = 0, cur_t = 0;
    int m_rate = 0, m_samp = 0, m_early = 0;
    logic [7:0] m_data [128];
    bit         m_en [128];

    task automatic finish_up();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual hung expected done");
        finish_up();
    end

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int blen(); return 4 << m_rate; endfunction
    function automatic int spt();
        int L = blen();
        if (m_samp == 1) return L/2 - 1;
        if (m_samp == 2) return L - 1;
        return 3*L/4 - 1;
    endfunction
    function automatic logic [7:0] pat_a(int s); return 8'((s*7 + 3) & 255); endfunction
    function automatic logic [7:0] pat_b(int s); return 8'((s*5) & 255) ^ 8'h5A; endfunction
    function automatic logic [7:0] pat_c(int s); return ~8'((s*11 + 1) & 255); endfunction
    function automatic logic [7:0] exp_byte(int s);
        if (m_samp == 1) return pat_a(s);
        if (m_samp == 2) return pat_c(s);
        return pat_b(s);
    endfunction
    function automatic logic rx_pat(int t);
        int L = blen(); int bi = t / L; int s = bi / 8; int k = bi % 8; int ph = t % L;
        logic [7:0] b;
        if (ph < L/2) b = pat_a(s); else if (ph < 3*L/4) b = pat_b(s); else b = pat_c(s);
        return b[7-k];
    endfunction
    function automatic logic exp_oe(int t);
        int L = blen(); int s = t / (8*L); int k = (t / L) % 8;
        return m_en[s] && !(m_early != 0 && k == 7 && (t % L) == L - 1);
    endfunction
    function automatic logic exp_d(int t);
        int L = blen(); int s = t / (8*L); int k = (t / L) % 8;
        return exp_oe(t) && m_data[s][7-k];
    endfunction

    // Advance one tick; a pulse driven this tick is released and restarts the count
    task automatic step();
        @(negedge clk);
        if (!frame_n) begin cur_t = 0; frame_n = 1'b1; end
        else cur_t = (cur_t + 1) % 4096;
        rx_d = rx_pat(cur_t);
    endtask

    task automatic do_reset(int rate, int samp, int early, int en_mode);
        m_rate = rate; m_samp = samp; m_early = early;
        rate_sel = 2'(rate); samp_sel = 2'(samp); early_rel = early[0];
        rst_n = 1'b0; frame_n = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int s = 0; s < 128; s++) begin
            m_data[s] = 8'((s*13 + 90) & 255);
            m_en[s]   = (en_mode == 0) ? ((s % 3) != 2) : 1'b1;
        end
        for (int s = 0; s < 128; s++) begin
            tx_wr = 1'b1; tx_waddr = 7'(s); tx_wdata = m_data[s]; tx_wslot_en = m_en[s];
            @(negedge clk);
        end
        tx_wr = 1'b0;
    endtask

    task automatic sync_frame();
        frame_n = 1'b0;
        step();
    endtask

    task automatic t_reset_hunt();
        int bad = 0;
        rst_n = 1'b0;
        @(negedge clk);
        chk(!tx_oe && !tx_d && !rx_valid && !sync_err && rx_slot == 0 && rx_byte == 0,
            "R1 reset outputs", {tx_oe, tx_d, rx_valid, sync_err}, 0);
        do_reset(0, 0, 0, 1);
        for (int n = 0; n < 300; n++) begin
            step();
            rx_d = n[0];
            if (tx_oe || rx_valid || sync_err) bad++;
        end
        chk(bad == 0, "R10 activity before frame pulse", bad, 0);
    endtask

    // One full frame from tick 0; optional correct pulse on tick 4095
    task automatic run_frame(bit pulse_end, string tg);
        int L = blen(); int P = spt(); int nslot = 128 >> m_rate;
        int txbad = 0, vbad = 0, got = 0, prev = -1, first_tx = -1;
        for (int n = 0; n <= 4096; n++) begin
            bit ev;
            int es;
            ev = (prev >= 0) && ((prev % (8*L)) == 7*L + P);
            es = (prev >= 0) ? prev / (8*L) : 0;
            if (rx_valid !== ev) vbad++;
            else if (ev) begin
                got++;
                if (rx_slot !== 7'(es) || rx_byte !== exp_byte(es)) vbad++;
            end
            if (n < 4096) begin
                if (tx_oe !== exp_oe(n) || tx_d !== exp_d(n)) begin
                    if (txbad == 0) first_tx = n;
                    txbad++;
                end
                if (n == 4095 && pulse_end) frame_n = 1'b0;
                prev = n;
                step();
            end
        end
        $display("frame %s done", tg);
        chk(txbad == 0, "R4 R5 R6 serial output per tick", first_tx, -1);
        chk(vbad == 0, "R7 R8 receive strobe and byte", vbad, 0);
        chk(got == nslot, "R3 bytes per frame", got, nslot);
        chk(tx_oe === exp_oe(0) && tx_d === exp_d(0), "R2 slot 0 b7 after frame", tx_d, exp_d(0));
        if (pulse_end) chk(sync_err == 1'b0, "R9 correct pulse keeps flag clear", sync_err, 0);
        else           chk(sync_err == 1'b1, "R9 missing pulse sets flag", sync_err, 1);
        for (int i = 0; i < 4; i++) begin
            int s = (i == 0) ? 0 : (i == 1) ? 1 : (i == 2) ? nslot/2 : nslot - 1;
            rx_raddr = 7'(s);
            #1;
            chk(rx_rdata === exp_byte(s), "R8 receive array readback", rx_rdata, exp_byte(s));
        end
    endtask

    task automatic t_misplaced();
        do_reset(0, 0, 0, 0);
        sync_frame();
        while (cur_t != 100) step();
        chk(sync_err == 1'b0, "R9 flag clear before fault", sync_err, 0);
        frame_n = 1'b0;
        step();
        chk(sync_err == 1'b1, "R9 misplaced pulse sets flag", sync_err, 1);
        chk(tx_oe === exp_oe(0) && tx_d === exp_d(0), "R2 realign to slot 0", tx_d, exp_d(0));
        repeat (40) step();
        chk(tx_oe === exp_oe(40) && tx_d === exp_d(40), "R2 slot 1 bit after realign", tx_d, exp_d(40));
        chk(sync_err == 1'b1, "R9 flag sticky", sync_err, 1);
    endtask

    initial begin
        t_reset_hunt();
        do_reset(0, 0, 0, 0); sync_frame(); run_frame(1'b1, "8M quarter3 sync-release");
        do_reset(1, 1, 1, 1); sync_frame(); run_frame(1'b0, "4M half early-release");
        do_reset(2, 2, 0, 0); sync_frame(); run_frame(1'b1, "2M full collision");
        do_reset(0, 3, 1, 0); sync_frame(); run_frame(1'b1, "8M alt-code early");
        t_misplaced();
        finish_up();
    end

endmodule